// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer. Its counting time base is a slow, free-running watchdog clock that is separate from the bus clock. Every edge of that slow clock goes through a prescaler with a power-of-two ratio. Each prescaler expiry decrements a 12-bit counter. If the counter runs out, the block drives a reset pulse of fixed length. When the pulse ends, the whole block returns to its default, stopped condition.

Software reaches the block through a small single-cycle register bus. The bus has a key register, a prescaler register, a reload register and a status register. Every action goes through a 16-bit key written to the key register:

- one value refreshes the counter;
- one value opens the configuration registers for writing;
- one value starts the watchdog.

Once started, the watchdog cannot be stopped by any write. New prescaler and reload values reach the counting logic only after two watchdog-clock edges. A busy flag for each register reports that delay.

The slow clock is oversampled in the bus clock domain. A two-stage synchronizer and an edge detector turn it into a one-cycle tick. A three-state machine sequences the counting: STOPPED, RUNNING and FIRING. Its transitions are:

- **arm**: STOPPED to RUNNING, on the start key.
- **expire**: RUNNING to FIRING, when the counter reaches zero.
- **release**: FIRING to STOPPED, after the pulse length.

Top module: `lockdog_wdt`

## Requirements
- R1: After reset, the divider register reads 0, the reload register reads 0xFFF, the status register reads 0, the reset output is low and the watchdog is stopped.
- R2: Writing key 0x5555 opens the divider and reload registers for writing. Any other key value closes them again. While they are closed, writes to them change nothing.
- R3: Divider codes 0 to 6 select tick ratios of 4, 8, 16, 32, 64, 128 and 256. Code 7 also selects 256. After start or refresh, the reset output rises after 4·2^code·reload watchdog-clock periods, within one period of phase uncertainty.
- R4: Writing key 0xAAAA copies the settled 12-bit reload value into the counter. Refreshing more often than the timeout keeps the reset output low indefinitely.
- R5: Writing key 0xCCCC starts the watchdog. No later write to any register stops it.
- R6: Status bit 0 is 1 while a divider update is pending, and status bit 1 is 1 while a reload update is pending. Each flag stays set for at least one watchdog-clock period and clears on the second watchdog-clock edge after the write. Writes to the status register have no effect.
- R7: A divider or reload write made while that register's busy flag is 1 is discarded.
- R8: The reset pulse lasts PULSE_TICKS watchdog-clock periods (4 by default). Afterwards every register is back at its R1 value, and the watchdog stays stopped.
- R9: The reload register keeps write-data bits [11:0], and the divider register keeps bits [2:0]. Higher bits are dropped.
- R10: The register map uses word addresses: 0 is the key register (reads 0), 1 is the divider, 2 is the reload value and 3 is the status.
- R11: The counter never increases except on refresh. It does not move while the watchdog is stopped, so a stopped watchdog never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdg_clk | input | 1 | Slow free-running watchdog time base |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on bus_addr while selected |
| wdg_rst_o | output | 1 | Watchdog reset pulse, high while firing |

## Verification
The checker assumes several things about the environment:
- The bus clock runs at least four times faster than the watchdog clock, so that every slow edge yields exactly one tick.
- Each bus write lasts exactly one bus cycle.
- No write arrives in the same cycle as the internal clear at the end of a pulse.

The bench keeps within these limits as follows:
- It holds the watchdog clock at one eighth of the bus rate, with an offset phase.
- It drives every access at falling edges, one cycle per write.
- It lets each pulse finish before the next configuration begins.

// File: rtl/lockdog_pkg.sv
package lockdog_pkg;
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY_FEED = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_OPEN = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_ARM  = 16'hCCCC;

    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_RUNNING = 2'd1,
        ST_FIRING  = 2'd2
    } dog_state_e;

    typedef enum logic [1:0] {
        ADDR_KEY    = 2'd0,
        ADDR_DIV    = 2'd1,
        ADDR_RELOAD = 2'd2,
        ADDR_STATUS = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/lockdog_tick_sync.sv
module lockdog_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk,
    output logic tick_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], slow_clk};
    end

    assign tick_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/lockdog_settle.sv
module lockdog_settle #(
    parameter int           W       = 3,
    parameter int           EDGES   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         tick_i,
    input  logic         wr_req_i,
    input  logic [W-1:0] wr_val_i,
    output logic [W-1:0] vis_o,
    output logic [W-1:0] act_o,
    output logic         busy_o
);
    localparam int EW = $clog2(EDGES + 1);

    logic [EW-1:0] edge_q;
    logic [W-1:0]  vis_q, act_q;
    logic          busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vis_q  <= RST_VAL;
            act_q  <= RST_VAL;
            busy_q <= 1'b0;
            edge_q <= '0;
        end else if (clear_i) begin
            vis_q  <= RST_VAL;
            act_q  <= RST_VAL;
            busy_q <= 1'b0;
            edge_q <= '0;
        end else if (wr_req_i && !busy_q) begin
            vis_q  <= wr_val_i;
            busy_q <= 1'b1;
            edge_q <= '0;
        end else if (busy_q && tick_i) begin
            if (edge_q == EW'(EDGES - 1)) begin
                busy_q <= 1'b0;
                act_q  <= vis_q;
                edge_q <= '0;
            end else begin
                edge_q <= edge_q + 1'b1;
            end
        end
    end

    assign vis_o  = vis_q;
    assign act_o  = act_q;
    assign busy_o = busy_q;
endmodule

// File: rtl/lockdog_regs.sv
module lockdog_regs
    import lockdog_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int CNT_W        = 12,
    parameter int DIV_W        = 3,
    parameter int SETTLE_EDGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              feed_o,
    output logic              arm_o,
    output logic              unlock_o,
    output logic              wr_div_o,
    output logic              wr_rel_o,
    output logic [DIV_W-1:0]  div_vis_o,
    output logic [DIV_W-1:0]  div_act_o,
    output logic              div_busy_o,
    output logic [CNT_W-1:0]  rel_vis_o,
    output logic [CNT_W-1:0]  rel_act_o,
    output logic              rel_busy_o
);
    logic             bus_write;
    logic             key_wr;
    logic [KEY_W-1:0] key_val;
    logic             unlock_q;

    assign bus_write = bus_sel_i && bus_wr_i;
    assign key_val   = bus_wdata_i[KEY_W-1:0];
    assign key_wr    = bus_write && (bus_addr_i == 2'(ADDR_KEY));
    assign wr_div_o  = bus_write && (bus_addr_i == 2'(ADDR_DIV));
    assign wr_rel_o  = bus_write && (bus_addr_i == 2'(ADDR_RELOAD));
    assign feed_o    = key_wr && (key_val == KEY_FEED);
    assign arm_o     = key_wr && (key_val == KEY_ARM);

    // Every key write decides the lock: only the open key leaves it open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       unlock_q <= 1'b0;
        else if (clear_i) unlock_q <= 1'b0;
        else if (key_wr)  unlock_q <= (key_val == KEY_OPEN);
    end
    assign unlock_o = unlock_q;

    lockdog_settle #(
        .W(DIV_W), .EDGES(SETTLE_EDGES), .RST_VAL('0)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .tick_i(tick_i),
        .wr_req_i(wr_div_o && unlock_q), .wr_val_i(bus_wdata_i[DIV_W-1:0]),
        .vis_o(div_vis_o), .act_o(div_act_o), .busy_o(div_busy_o)
    );

    lockdog_settle #(
        .W(CNT_W), .EDGES(SETTLE_EDGES), .RST_VAL('1)
    ) u_rel (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .tick_i(tick_i),
        .wr_req_i(wr_rel_o && unlock_q), .wr_val_i(bus_wdata_i[CNT_W-1:0]),
        .vis_o(rel_vis_o), .act_o(rel_act_o), .busy_o(rel_busy_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i) begin
            unique case (bus_addr_i)
                2'(ADDR_DIV):    bus_rdata_o[DIV_W-1:0] = div_vis_o;
                2'(ADDR_RELOAD): bus_rdata_o[CNT_W-1:0] = rel_vis_o;
                2'(ADDR_STATUS): bus_rdata_o[1:0]       = {rel_busy_o, div_busy_o};
                default:         bus_rdata_o            = '0;
            endcase
        end
    end
endmodule

// File: rtl/lockdog_core.sv
module lockdog_core
    import lockdog_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int DIV_W       = 3,
    parameter int MIN_LOG     = 2,
    parameter int MAX_LOG     = 8,
    parameter int PULSE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             feed_i,
    input  logic             arm_i,
    input  logic [DIV_W-1:0] div_code_i,
    input  logic [CNT_W-1:0] reload_i,
    output dog_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             rst_pulse_o,
    output logic             clear_o
);
    localparam int PRE_W = MAX_LOG;
    localparam int PW    = $clog2(PULSE_TICKS + 1);

    dog_state_e       state_q, state_d;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    pulse_q;
    logic [PRE_W-1:0] pre_last;
    logic             pre_wrap, expire, release_now;

    function automatic logic [PRE_W-1:0] div_last(input logic [DIV_W-1:0] code);
        int sh;
        sh = int'(code) + MIN_LOG;
        if (sh > MAX_LOG) sh = MAX_LOG;
        return PRE_W'((1 << sh) - 1);
    endfunction

    assign pre_last    = div_last(div_code_i);
    assign pre_wrap    = tick_i && (pre_q == pre_last);
    assign expire      = !feed_i && ((tick_i && cnt_q == '0) ||
                                     (pre_wrap && cnt_q == CNT_W'(1)));
    assign release_now = tick_i && (pulse_q == PW'(PULSE_TICKS - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // Transitions: arm, expire, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (arm_i)       state_d = ST_RUNNING;
            ST_RUNNING: if (expire)      state_d = ST_FIRING;
            ST_FIRING:  if (release_now) state_d = ST_STOPPED;
            default:                     state_d = ST_STOPPED;
        endcase
    end

    // Prescaler, counter and pulse-length datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            cnt_q   <= '1;
            pulse_q <= '0;
        end else begin
            unique case (state_q)
                ST_STOPPED: begin
                    if (feed_i) cnt_q <= reload_i;
                    pre_q   <= '0;
                    pulse_q <= '0;
                end
                ST_RUNNING: begin
                    pulse_q <= '0;
                    if (feed_i) begin
                        cnt_q <= reload_i;
                        pre_q <= '0;
                    end else if (pre_wrap) begin
                        pre_q <= '0;
                        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                    end else if (tick_i) begin
                        pre_q <= pre_q + 1'b1;
                    end
                end
                ST_FIRING: begin
                    if (release_now) begin
                        cnt_q   <= '1;
                        pre_q   <= '0;
                        pulse_q <= '0;
                    end else if (tick_i) begin
                        pulse_q <= pulse_q + 1'b1;
                    end
                end
                default: begin
                    pre_q   <= '0;
                    cnt_q   <= '1;
                    pulse_q <= '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        state_o     = state_q;
        cnt_o       = cnt_q;
        rst_pulse_o = (state_q == ST_FIRING);
        clear_o     = (state_q == ST_FIRING) && release_now;
    end
endmodule

// File: rtl/lockdog_wdt.sv
module lockdog_wdt
    import lockdog_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int CNT_W        = 12,
    parameter int DIV_W        = 3,
    parameter int SYNC_STAGES  = 2,
    parameter int SETTLE_EDGES = 2,
    parameter int PULSE_TICKS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdg_clk,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdg_rst_o
);
    logic             tick;
    logic             feed, arm, unlock, wr_div, wr_rel, clear;
    logic [DIV_W-1:0] div_vis, div_act;
    logic [CNT_W-1:0] rel_vis, rel_act, core_cnt;
    logic             div_busy, rel_busy;
    dog_state_e       core_state;

    lockdog_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .slow_clk(wdg_clk), .tick_o(tick)
    );

    lockdog_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .SETTLE_EDGES(SETTLE_EDGES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .tick_i(tick),
        .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .feed_o(feed), .arm_o(arm), .unlock_o(unlock),
        .wr_div_o(wr_div), .wr_rel_o(wr_rel),
        .div_vis_o(div_vis), .div_act_o(div_act), .div_busy_o(div_busy),
        .rel_vis_o(rel_vis), .rel_act_o(rel_act), .rel_busy_o(rel_busy)
    );

    lockdog_core #(
        .CNT_W(CNT_W), .DIV_W(DIV_W), .PULSE_TICKS(PULSE_TICKS)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .feed_i(feed), .arm_i(arm),
        .div_code_i(div_act), .reload_i(rel_act),
        .state_o(core_state), .cnt_o(core_cnt),
        .rst_pulse_o(wdg_rst_o), .clear_o(clear)
    );
endmodule

// File: rtl/lockdog_wdt_chk.sv
module lockdog_wdt_chk
    import lockdog_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int DIV_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input dog_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic             feed,
    input logic             unlock,
    input logic             wr_div,
    input logic             wr_rel,
    input logic             clear,
    input logic [DIV_W-1:0] div_vis,
    input logic [DIV_W-1:0] div_act,
    input logic             div_busy,
    input logic [CNT_W-1:0] rel_vis,
    input logic [CNT_W-1:0] rel_act,
    input logic             rel_busy,
    input logic             wdg_rst_o
);
    assert_fire_from_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdg_rst_o) |-> $past(state == ST_RUNNING));

    assert_no_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUNNING) |=> (state != ST_STOPPED));

    assert_count_down_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FIRING && !feed) |=> (cnt <= $past(cnt)));

    assert_locked_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_div && !unlock && !clear) |=> $stable(div_vis));

    assert_locked_rel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rel && !unlock && !clear) |=> $stable(rel_vis));

    assert_busy_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_div && div_busy && !clear) |=> $stable(div_vis));

    assert_settled_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_busy) |-> (div_act == div_vis));

    assert_settled_rel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rel_busy) |-> (rel_act == rel_vis));
endmodule

bind lockdog_wdt lockdog_wdt_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(core_state), .cnt(core_cnt), .feed(feed),
    .unlock(unlock), .wr_div(wr_div), .wr_rel(wr_rel), .clear(clear),
    .div_vis(div_vis), .div_act(div_act), .div_busy(div_busy),
    .rel_vis(rel_vis), .rel_act(rel_act), .rel_busy(rel_busy),
    .wdg_rst_o(wdg_rst_o)
);

// File: tb/lockdog_wdt_tb.sv
module lockdog_wdt_tb;
    localparam int P     = 8;     // bus cycles per watchdog-clock period
    localparam int PULSE = 4;

    logic        clk, rst_n, wdg_clk;
    logic        bus_sel, bus_wr;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        wdg_rst_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    lockdog_wdt u_dut (
        .clk(clk), .rst_n(rst_n), .wdg_clk(wdg_clk),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdg_rst_o(wdg_rst_o)
    );

    initial begin clk = 0; forever #5 clk = ~clk; end
    initial begin wdg_clk = 0; #3; forever #40 wdg_clk = ~wdg_clk; end

    function automatic int ticks_for(input int code, input int rl);
        int sh;
        sh = code + 2;
        if (sh > 8) sh = 8;
        return (1 << sh) * rl;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_range(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = int'(bus_rdata);
        bus_sel = 0;
    endtask

    // cycles until status becomes zero, -1 if it never does
    task automatic wait_idle(output int c);
        int s;
        c = 0;
        for (int i = 1; i < 1000; i++) begin
            rd(2'd3, s);
            if (s == 0) begin c = i; return; end
        end
        c = -1;
    endtask

    task automatic wait_rst(input int max, output int c);
        c = -1;
        for (int i = 1; i <= max; i++) begin
            @(negedge clk);
            if (wdg_rst_o) begin c = i; return; end
        end
    endtask

    task automatic pulse_len(output int w);
        w = 0;
        while (wdg_rst_o && w < 1000) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic configure(input int code, input int rl);
        int c;
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(code));
        wr(2'd2, 16'(rl));
        wait_idle(c);
    endtask

    task automatic timed_run(input string tag, input int code, input int rl);
        int c, n;
        configure(code, rl);
        wr(2'd0, 16'hAAAA);
        wr(2'd0, 16'hCCCC);
        n = ticks_for(code, rl) * P;
        wait_rst(n + 50, c);
        check_range(tag, c, n - P, n + 1);
        pulse_len(c);
    endtask

    initial begin
        #(10 * 190000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, c, w, code, rl;
        bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        rst_n = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R1 / R10 reset state and map
        rd(2'd1, v); check("R1 divider default", v, 0);
        rd(2'd2, v); check("R1 reload default", v, 12'hFFF);
        rd(2'd3, v); check("R1 status default", v, 0);
        rd(2'd0, v); check("R10 key reads zero", v, 0);
        check("R1 reset output low", int'(wdg_rst_o), 0);

        // R2 locked write ignored
        wr(2'd1, 16'd6);
        rd(2'd1, v); check("R2 locked divider write", v, 0);
        rd(2'd3, v); check("R2 locked write leaves status", v, 0);

        // R11 stopped watchdog never fires, even after refresh
        wr(2'd0, 16'hAAAA);
        wait_rst(2000, c); check("R11 stopped never fires", c, -1);

        // R2 other key relocks
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'd5);
        rd(2'd1, v); check("R2 relock by other key", v, 0);

        // R6 busy flag timing for divider
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd5);
        wait_idle(c); check_range("R6 divider busy duration", c, P, 2 * P + 1);
        rd(2'd1, v); check("R6 divider accepted", v, 5);

        // R7 write during busy discarded
        wr(2'd1, 16'd3);
        wr(2'd1, 16'd2);
        rd(2'd3, v); check("R6 status bit0 set", v, 1);
        wait_idle(c);
        rd(2'd1, v); check("R7 busy write discarded", v, 3);

        // R9 reload truncation, R6 bit1
        wr(2'd2, 16'hF123);
        rd(2'd3, v); check("R6 status bit1 set", v, 2);
        wait_idle(c); check_range("R6 reload busy duration", c, P, 2 * P + 1);
        rd(2'd2, v); check("R9 reload low 12 bits", v, 12'h123);
        wr(2'd3, 16'hFFFF);
        rd(2'd3, v); check("R6 status write ignored", v, 0);

        // R3 code 7 maps to 256, then R8 pulse and defaults
        configure(7, 2);
        wr(2'd0, 16'hAAAA);
        wr(2'd0, 16'hCCCC);
        wait_rst(ticks_for(7, 2) * P + 50, c);
        check_range("R3 code7 timeout", c, ticks_for(7, 2) * P - P, ticks_for(7, 2) * P + 1);
        pulse_len(w); check_range("R8 pulse width", w, PULSE * P - 1, PULSE * P + 1);
        rd(2'd1, v); check("R8 divider back to default", v, 0);
        rd(2'd2, v); check("R8 reload back to default", v, 12'hFFF);
        wait_rst(1500, c); check("R8 stopped after pulse", c, -1);

        // R5 junk writes cannot stop it
        configure(0, 30);
        wr(2'd0, 16'hAAAA);
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h5555);
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h1234);
        wait_rst(ticks_for(0, 30) * P + 50, c);
        checks++;
        if (c < 0) begin
            errors++;
            $display("FAIL R5 no reset after start actual=none expected=pulse");
        end
        pulse_len(w);

        // R4 refresh keeps it alive, then lapses
        configure(1, 20);
        wr(2'd0, 16'hAAAA);
        wr(2'd0, 16'hCCCC);
        for (int i = 0; i < 6; i++) begin
            wait_rst(800, c); check("R4 refresh holds off reset", c, -1);
            wr(2'd0, 16'hAAAA);
        end
        wait_rst(ticks_for(1, 20) * P + 50, c);
        check_range("R4 timeout after last refresh", c,
                    ticks_for(1, 20) * P - P, ticks_for(1, 20) * P + 1);
        pulse_len(w);

        // R3 constrained random timeouts
        void'($urandom(32'd2024));
        for (int k = 0; k < 5; k++) begin
            code = int'($urandom % 3);
            rl   = 3 + int'($urandom % 28);
            timed_run("R3 random timeout", code, rl);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule